// File: doc/BRIEF.md
# Ballot Vote Tally Unit

This unit keeps a running vote count for each of several candidates. Each candidate has its own ballot input line. A ballot strobe marks the cycles in which the ballot lines carry a vote. When the strobe is high, the raised line with the lowest number is encoded into a candidate index. A decoder turns that index into the write enable of that candidate's tally register. A single shared incrementer adds one to the tally that is read out, and the sum is written back at the next clock edge.

A single read multiplexer serves both the incrementer and the display output. In a cycle that counts a vote, it selects the voted candidate. In every other cycle, it selects the candidate named by the view-select input. This lets a display path watch any tally without extra read ports. The unit has eight candidates and 32-bit tallies by default. Both are parameters.

Top module: `vote_tally`

## Requirements
- R1: While `rst_ni` is low, every tally register is cleared to zero. Reading each candidate through `view_sel_i` after reset shows 0.
- R2: A vote is counted when `detect_i` is high and `ballot_i` is nonzero. The tally of the chosen candidate rises by exactly one at the next rising clock edge.
- R3: When several ballot lines are high in a counting cycle, only the candidate with the lowest set bit position counts the vote. Bit k of `ballot_i` is candidate k. All other tallies are unchanged.
- R4: While `detect_i` is low, `ballot_i` has no effect on any tally.
- R5: When `detect_i` is high and `ballot_i` is all zero, no tally changes.
- R6: At most one vote is counted per clock cycle. Holding the same ballot with `detect_i` high for n consecutive cycles adds exactly n to that tally.
- R7: A tally at its maximum value (all ones) wraps to zero when it receives one more vote.
- R8: In a cycle that counts no vote, `tally_o` combinationally shows the stored tally of the candidate whose index is on `view_sel_i`.
- R9: In a counting cycle, `tally_o` shows the voted candidate's value before the increment, and `view_sel_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ballot_i | input | N_CAND | Ballot lines, one per candidate |
| detect_i | input | 1 | High when the ballot lines carry a vote |
| view_sel_i | input | $clog2(N_CAND) | Candidate to show when no vote is counted |
| tally_o | output | TALLY_W | Selected tally value |

## Verification
The assertions assume that `detect_i` and `ballot_i` are synchronous to `clk_i` and stable around each rising edge. They also assume that a counting cycle is defined only by `detect_i` being high together with a nonzero `ballot_i`. The stimulus changes every input only on falling edges and samples `tally_o` shortly after them. Vote patterns include single lines, several lines at once, a strobe without ballots, and ballots without a strobe. The bench narrows the tally width so that a wrap to zero can be reached in a few hundred votes.

// File: rtl/vote_pkg.sv
package vote_pkg;
  localparam int unsigned DEF_N_CAND  = 8;
  localparam int unsigned DEF_TALLY_W = 32;
endpackage

// File: rtl/ballot_encoder.sv
module ballot_encoder #(
  parameter int unsigned N_CAND = vote_pkg::DEF_N_CAND,
  localparam int unsigned IDX_W = $clog2(N_CAND)
) (
  input  logic [N_CAND-1:0] ballot_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  // scan downward so the lowest raised line is the last assignment
  always_comb begin
    idx_o = '0;
    for (int k = N_CAND - 1; k >= 0; k--) begin
      if (ballot_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign any_o = |ballot_i;
endmodule

// File: rtl/tally_decoder.sv
module tally_decoder #(
  parameter int unsigned N_CAND = vote_pkg::DEF_N_CAND,
  localparam int unsigned IDX_W = $clog2(N_CAND)
) (
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [N_CAND-1:0] we_o
);
  for (genvar k = 0; k < N_CAND; k++) begin : g_we
    assign we_o[k] = en_i && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/tally_bank.sv
module tally_bank #(
  parameter int unsigned N_CAND  = vote_pkg::DEF_N_CAND,
  parameter int unsigned TALLY_W = vote_pkg::DEF_TALLY_W,
  localparam int unsigned IDX_W  = $clog2(N_CAND)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_CAND-1:0]               we_i,
  input  logic [IDX_W-1:0]                rd_sel_i,
  output logic [TALLY_W-1:0]              rd_data_o,
  output logic [N_CAND-1:0][TALLY_W-1:0]  tally_q_o
);
  logic [TALLY_W-1:0] inc_val;

  assign rd_data_o = tally_q_o[rd_sel_i];
  assign inc_val   = rd_data_o + 1'b1;  // shared incrementer, wraps naturally

  for (genvar k = 0; k < N_CAND; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tally_q_o[k] <= '0;
      else if (we_i[k]) tally_q_o[k] <= inc_val;
    end
  end
endmodule

// File: rtl/vote_tally.sv
module vote_tally #(
  parameter int unsigned N_CAND  = vote_pkg::DEF_N_CAND,
  parameter int unsigned TALLY_W = vote_pkg::DEF_TALLY_W,
  localparam int unsigned IDX_W  = $clog2(N_CAND)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAND-1:0]  ballot_i,
  input  logic               detect_i,
  input  logic [IDX_W-1:0]   view_sel_i,
  output logic [TALLY_W-1:0] tally_o
);
  logic [IDX_W-1:0]                cand_idx;
  logic                            any_ballot;
  logic                            wr_vote;
  logic [IDX_W-1:0]                rd_sel;
  logic [N_CAND-1:0]               we_vec;
  logic [N_CAND-1:0][TALLY_W-1:0]  tally_q;

  ballot_encoder #(.N_CAND(N_CAND)) u_enc (
    .ballot_i (ballot_i),
    .idx_o    (cand_idx),
    .any_o    (any_ballot)
  );

  assign wr_vote = detect_i && any_ballot;
  // vote owns the read port; otherwise the viewer does
  assign rd_sel  = wr_vote ? cand_idx : view_sel_i;

  tally_decoder #(.N_CAND(N_CAND)) u_dec (
    .en_i  (wr_vote),
    .idx_i (cand_idx),
    .we_o  (we_vec)
  );

  tally_bank #(.N_CAND(N_CAND), .TALLY_W(TALLY_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_vec),
    .rd_sel_i  (rd_sel),
    .rd_data_o (tally_o),
    .tally_q_o (tally_q)
  );
endmodule

// File: rtl/vote_tally_chk.sv
module vote_tally_chk #(
  parameter int unsigned N_CAND  = vote_pkg::DEF_N_CAND,
  parameter int unsigned TALLY_W = vote_pkg::DEF_TALLY_W,
  localparam int unsigned IDX_W  = $clog2(N_CAND)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_CAND-1:0]               ballot_i,
  input logic                            detect_i,
  input logic [IDX_W-1:0]                view_sel_i,
  input logic [TALLY_W-1:0]              tally_o,
  input logic [N_CAND-1:0]               we_vec,
  input logic [IDX_W-1:0]                cand_idx,
  input logic [N_CAND-1:0][TALLY_W-1:0]  tally_q
);
  logic vote_c;
  assign vote_c = detect_i && (ballot_i != '0);

  assert_one_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_vec));

  assert_no_strobe_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_i |-> (we_vec == '0));

  assert_empty_ballot_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_i && ballot_i == '0) |-> (we_vec == '0));

  assert_lowest_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vote_c |-> (we_vec == (ballot_i & N_CAND'(~ballot_i + 1'b1))));

  assert_step_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vote_c |=> (tally_q[$past(cand_idx)] == TALLY_W'($past(tally_o) + 1'b1)));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vote_c |=> $stable(tally_q));

  assert_view_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vote_c |-> (tally_o == tally_q[view_sel_i]));
endmodule

bind vote_tally vote_tally_chk #(.N_CAND(N_CAND), .TALLY_W(TALLY_W)) u_chk (.*);

// File: tb/vote_tally_tb.sv
module vote_tally_tb;
  localparam int unsigned NC = 8;
  localparam int unsigned TW = 8;
  localparam int unsigned IW = $clog2(NC);

  typedef struct {
    string         req;
    logic [TW-1:0] exp;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] ballot_i = '0;
  logic          detect_i = 1'b0;
  logic [IW-1:0] view_sel_i = '0;
  logic [TW-1:0] tally_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb_q[$];
  logic [TW-1:0] model [NC];

  always #5 clk_i = ~clk_i;

  vote_tally #(.N_CAND(NC), .TALLY_W(TW)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ballot_i   (ballot_i),
    .detect_i   (detect_i),
    .view_sel_i (view_sel_i),
    .tally_o    (tally_o)
  );

  // monitor: samples 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_run++;
        if (tally_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: tally_o=%0d expected=%0d", it.req, tally_o, it.exp);
        end
      end
    end
  end

  task automatic cast(input logic [NC-1:0] b, input logic det, input logic [IW-1:0] vs,
                      input string req);
    @(negedge clk_i);
    ballot_i   = b;
    detect_i   = det;
    view_sel_i = vs;
    if (det && b != '0) begin
      int k = 0;
      while (!b[k]) k++;
      sb_q.push_back('{req, model[k]});  // R9: pre-increment value shown
      model[k] = model[k] + 1'b1;
    end else begin
      sb_q.push_back('{req, model[vs]});
    end
  endtask

  task automatic peek(input logic [IW-1:0] sel, input logic [NC-1:0] noise, input string req);
    @(negedge clk_i);
    ballot_i   = noise;
    detect_i   = 1'b0;
    view_sel_i = sel;
    sb_q.push_back('{req, model[sel]});
  endtask

  task automatic peek_all(input string req);
    for (int k = 0; k < NC; k++) peek(IW'(k), '0, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) model[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    peek_all("R1");

    // R2: candidate k receives k+1 single-line votes
    for (int k = 0; k < NC; k++)
      for (int v = 0; v <= k; v++) cast(NC'(1) << k, 1'b1, IW'(NC - 1 - k), "R9");
    peek_all("R2");

    // R3: several lines raised, lowest wins
    cast(8'b1010_0100, 1'b1, 3'd7, "R3");
    cast(8'b1111_1110, 1'b1, 3'd0, "R3");
    cast(8'b1000_0000, 1'b1, 3'd0, "R3");
    peek_all("R3");

    // R4: ballots ignored without strobe
    peek(3'd3, 8'hFF, "R4");
    peek(3'd0, 8'h01, "R4");
    peek_all("R4");

    // R5: strobe with empty ballot
    cast('0, 1'b1, 3'd5, "R5");
    cast('0, 1'b1, 3'd6, "R8");
    peek_all("R5");

    // R6: held strobe counts once per cycle
    for (int v = 0; v < 5; v++) cast(8'b0001_0000, 1'b1, 3'd1, "R6");
    peek(3'd4, '0, "R6");

    // R8: view select sweep, reverse order
    for (int k = NC - 1; k >= 0; k--) peek(IW'(k), '0, "R8");

    // R7: wrap of candidate 7
    while (model[7] != {TW{1'b1}}) cast(8'h80, 1'b1, 3'd2, "R9");
    peek(3'd7, '0, "R7");
    cast(8'h80, 1'b1, 3'd0, "R7");
    peek(3'd7, '0, "R7");
    peek_all("R7");

    @(negedge clk_i);
    detect_i = 1'b0;
    ballot_i = '0;
    repeat (2) @(negedge clk_i);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule